// File: doc/BRIEF.md
# Serial Peripheral Port with Decoded Selects

A full-duplex, byte-wide synchronous serial port. As a master it derives its serial clock from the system clock through a 16-bit divisor. It exchanges eight bits at a time, most significant bit first: one bit goes out on `mosi_o` while one bit comes in on `miso_i`. It drives one of three active-low select lines toward the addressed peripheral. Clock polarity and clock phase are both programmable.

An external master can take the port over by pulling `ss_ni` low. The port then becomes a slave. It shifts in on `mosi_i` under the external clock `sck_i` and shifts out on `miso_o`. All three slave-side inputs pass through two-stage synchronizers before use.

A host reaches the port through a four-word register interface. Writes take effect at the clock edge where `reg_we_i` is high. Reads are combinational from `reg_addr_i`.

| Address | Read | Write |
|---|---|---|
| 0 | divisor | divisor |
| 1 | control: bit 0 polarity, bit 1 phase, bits 3:2 select index | control |
| 2 | last transmit byte | transmit byte in bits 7:0 |
| 3 | status: bit 9 busy, bit 8 done, bits 7:0 received byte | ignored |

Top module: `spi_port`

## Requirements
- R1: In master mode each half-period of `sck_o` lasts D system-clock cycles, where D is the divisor. The busy bit (status bit 9) stays high for exactly 17·D cycles per transfer.
- R2: Divisor values 0 and 1 behave exactly like 2. The serial clock never runs faster than one quarter of the system clock, and no level of `sck_o` lasts less than two cycles during a transfer.
- R3: A transfer exchanges 8 bits MSB first, full duplex. Status bits 7:0 then hold the byte that was shifted in on `miso_i`. The peripheral receives the byte that was written to address 2.
- R4: Control bit 0 sets the level of `sck_o` at idle, and `sck_o` returns to that level after 16 edges. Control bit 1 selects the phase:
  - phase 0: input is sampled on the edge leaving idle and output changes on the edge returning to idle;
  - phase 1: the edges are swapped.
- R5: A select index n in control bits 3:2, with n from 1 to 3, drives `sel_no[n-1]` low while busy. Index 0 drives no select. At most one select is ever low.
- R6: The select goes low one half-period before the first clock edge and goes high one half-period after the sixteenth edge. All selects are high while idle.
- R7: A master transfer starts only on a write to address 2 while idle with `ss_ni` high. A write to address 2 during a transfer neither restarts it nor alters the byte being sent.
- R8: The done bit (status bit 8) is cleared when a transfer starts. It is set once the eighth bit has been sampled.
- R9: While `ss_ni` is low the port is a slave:
  - it samples `mosi_i` on `sck_i` edges using the same polarity and phase rules;
  - it shifts its transmit byte out on `miso_o`, MSB first;
  - it loads that byte when `ss_ni` falls, or on a write to address 2;
  - it starts no master transfer and keeps all selects high.
- R10: After reset every select is high, `sck_o` is low, and the divisor and status registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master serial data out |
| miso_i | input | 1 | Master serial data in |
| sel_no | output | 3 | Peripheral selects, active low |
| ss_ni | input | 1 | Slave select from an external master, active low |
| sck_i | input | 1 | Serial clock from an external master |
| mosi_i | input | 1 | Slave serial data in |
| miso_o | output | 1 | Slave serial data out |

## Verification
Master transfers are walked over all four polarity/phase combinations, so a swapped sampling edge or a wrong idle level corrupts the exchanged bytes. Divisors 2, 3, 4 and 5 separate a correct half-period length from an off-by-one count. Divisors 0 and 1 show the clamp to 2. Each of the four select indices is used, which exposes a mis-decoded or extra select line. A mid-transfer write and slave-mode exchanges in two clock modes check, respectively, that a busy port is not disturbed and that the external-master path neither starts the master nor drives the selects.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TAIL} mstate_e;
  localparam logic [1:0] ADDR_DIV  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_TX   = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_port_divider.sv
module spi_port_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] lim, cnt_q;

  // divisor below the minimum is clamped
  assign lim    = (div_i < MIN_DIV) ? (MIN_DIV - DIV_W'(1)) : (div_i - DIV_W'(1));
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              lead_i,
  input  logic              trail_i,
  input  logic              cpha_i,
  input  logic              sin_i,
  output logic              sout_o,
  output logic [WORD_W-1:0] rx_o,
  output logic              word_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] tx_q, rx_q;
  logic [CNT_W-1:0]  nsamp_q;
  logic              first_q, word_q;
  logic              sample, change;

  assign sample = cpha_i ? trail_i : lead_i;
  assign change = cpha_i ? lead_i  : trail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q    <= '0;
      rx_q    <= '0;
      nsamp_q <= '0;
      first_q <= 1'b1;
      word_q  <= 1'b0;
    end else if (load_i) begin
      tx_q    <= data_i;
      nsamp_q <= '0;
      first_q <= 1'b1;
      word_q  <= 1'b0;
    end else begin
      word_q <= sample && (nsamp_q == CNT_W'(WORD_W - 1));
      if (sample) begin
        rx_q    <= {rx_q[WORD_W-2:0], sin_i};
        nsamp_q <= nsamp_q + CNT_W'(1);
      end
      if (change) begin
        first_q <= 1'b0;
        // phase 1: MSB is already on the line at the first change edge
        if (!(cpha_i && first_q)) tx_q <= {tx_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign sout_o = tx_q[WORD_W-1];
  assign rx_o   = rx_q;
  assign word_o = word_q;
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int WORD_W = 8,
  parameter int NSEL   = 3,
  parameter int REG_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [NSEL-1:0]  sel_no,
  input  logic             ss_ni,
  input  logic             sck_i,
  input  logic             mosi_i,
  output logic             miso_o
);
  localparam int SEL_W  = $clog2(NSEL + 1);
  localparam int EDGES  = 2 * WORD_W;
  localparam int EDGE_W = $clog2(EDGES);

  mstate_e           state_q;
  logic [DIV_W-1:0]  div_q;
  logic              cpol_q, cpha_q;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] tx_q, rx_q, sh_rx;
  logic              done_q, sck_q;
  logic [EDGE_W-1:0] edge_q;
  logic              busy, tick, m_edge, m_lead, m_trail;
  logic              ss_s, sck_s, mosi_s, ss_p, sck_p;
  logic              slave_act, s_lead, s_trail, tx_wr, start, sh_load, word, sout;

  // slave-side inputs
  spi_port_sync #(.W(3), .STAGES(2), .RST(3'b100)) i_sync (
    .clk_i, .rst_ni,
    .d_i ({ss_ni, sck_i, mosi_i}),
    .q_o ({ss_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_p  <= 1'b1;
      sck_p <= 1'b0;
    end else begin
      ss_p  <= ss_s;
      sck_p <= sck_s;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign tx_wr     = reg_we_i && (reg_addr_i == ADDR_TX);
  assign start     = tx_wr && !busy && ss_s;
  assign slave_act = !ss_s && !busy;
  assign s_lead    = slave_act && (sck_s != cpol_q) && (sck_p == cpol_q);
  assign s_trail   = slave_act && (sck_s == cpol_q) && (sck_p != cpol_q);
  assign sh_load   = start || (slave_act && (tx_wr || ss_p));

  spi_port_divider #(.DIV_W(DIV_W)) i_div (
    .clk_i, .rst_ni,
    .run_i  (busy),
    .div_i  (div_q),
    .tick_o (tick)
  );

  assign m_edge  = tick && (state_q == ST_LEAD || state_q == ST_XFER);
  assign m_lead  = m_edge && !edge_q[0];
  assign m_trail = m_edge &&  edge_q[0];

  spi_port_shifter #(.WORD_W(WORD_W)) i_shift (
    .clk_i, .rst_ni,
    .load_i  (sh_load),
    .data_i  (tx_wr ? reg_wdata_i[WORD_W-1:0] : tx_q),
    .lead_i  (m_lead  || s_lead),
    .trail_i (m_trail || s_trail),
    .cpha_i  (cpha_q),
    .sin_i   (busy ? miso_i : mosi_s),
    .sout_o  (sout),
    .rx_o    (sh_rx),
    .word_o  (word)
  );

  // host registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      cpol_q <= 1'b0;
      cpha_q <= 1'b0;
      sel_q  <= '0;
      tx_q   <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        ADDR_DIV:  div_q <= reg_wdata_i[DIV_W-1:0];
        ADDR_CTRL: begin
          cpol_q <= reg_wdata_i[0];
          cpha_q <= reg_wdata_i[1];
          sel_q  <= reg_wdata_i[2 +: SEL_W];
        end
        ADDR_TX:   tx_q <= reg_wdata_i[WORD_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= '0;
      done_q <= 1'b0;
    end else if (sh_load) begin
      done_q <= 1'b0;
    end else if (word) begin
      rx_q   <= sh_rx;
      done_q <= 1'b1;
    end
  end

  // master sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      sck_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LEAD;
          edge_q  <= '0;
          sck_q   <= cpol_q;
        end
        ST_LEAD: if (tick) begin
          state_q <= ST_XFER;
          edge_q  <= edge_q + EDGE_W'(1);
          sck_q   <= !sck_q;
        end
        ST_XFER: if (tick) begin
          edge_q <= edge_q + EDGE_W'(1);
          sck_q  <= !sck_q;
          if (edge_q == EDGE_W'(EDGES - 1)) state_q <= ST_TAIL;
        end
        ST_TAIL: if (tick) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NSEL; i++) begin : g_sel
    assign sel_no[i] = !(busy && (sel_q == SEL_W'(i + 1)));
  end

  assign sck_o  = busy ? sck_q : cpol_q;
  assign mosi_o = sout;
  assign miso_o = sout;

  always_comb begin
    case (reg_addr_i)
      ADDR_DIV:  reg_rdata_o = REG_W'(div_q);
      ADDR_CTRL: reg_rdata_o = REG_W'({sel_q, cpha_q, cpol_q});
      ADDR_TX:   reg_rdata_o = REG_W'(tx_q);
      default:   reg_rdata_o = REG_W'({busy, done_q, rx_q});
    endcase
  end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int NSEL = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sck_o,
  input logic [NSEL-1:0] sel_no,
  input logic            cpol_i,
  input logic            sck_int_i,
  input logic            busy_i,
  input logic            ss_s_i
);
  // R5
  p_sel_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~sel_no));

  // R6
  p_sel_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (&sel_no));

  // R4: even number of edges brings the clock back to the idle level
  p_sck_return_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (sck_int_i == cpol_i));

  // R2
  p_half_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !$stable(sck_o)) |=> $stable(sck_o));

  // R9
  p_slave_no_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ss_s_i && !busy_i) |=> !busy_i);
endmodule

bind spi_port spi_port_chk #(.NSEL(NSEL)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sck_o     (sck_o),
  .sel_no    (sel_no),
  .cpol_i    (cpol_q),
  .sck_int_i (sck_q),
  .busy_i    (busy),
  .ss_s_i    (ss_s)
);

// File: tb/test_spi_port.sv
module test_spi_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd3;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sck_o, mosi_o, miso_o, ss_n, sck_in, mosi_in;
  logic [2:0]  sel_no;
  logic [7:0]  m_tx, m_rx;
  logic        m_first, model_on, tb_cpol, tb_cpha;
  int          n_tests = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_port i_spi_port (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_i(m_tx[7]), .sel_no(sel_no), .ss_ni(ss_n), .sck_i(sck_in),
    .mosi_i(mosi_in), .miso_o(miso_o)
  );

  // peripheral model on the master side
  always @(sck_o) begin
    if (model_on) begin
      if ((sck_o != tb_cpol) == !tb_cpha) m_rx = {m_rx[6:0], mosi_o};
      else begin
        if (!(tb_cpha && m_first)) m_tx = {m_tx[6:0], 1'b0};
        m_first = 1'b0;
      end
    end
  end

  typedef struct packed {
    logic [15:0] baud;
    logic        cpol;
    logic        cpha;
    logic [1:0]  sel;
    logic [7:0]  tx;
    logic [7:0]  stx;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd2, 1'b0, 1'b0, 2'd1, 8'hA5, 8'h3C},
    '{16'd3, 1'b0, 1'b1, 2'd2, 8'h81, 8'h7E},
    '{16'd5, 1'b1, 1'b0, 2'd3, 8'h0F, 8'hF0},
    '{16'd4, 1'b1, 1'b1, 2'd1, 8'hC3, 8'h96},
    '{16'd0, 1'b0, 1'b0, 2'd2, 8'hFF, 8'h00},
    '{16'd1, 1'b1, 1'b1, 2'd0, 8'h5A, 8'hA5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
    addr = 2'd3;
  endtask

  // one master transfer, optional write of 'late' at busy cycle 10
  task automatic master(input vec_t v, input bit mid_wr, input logic [7:0] late);
    int div, busy_cyc, toggles;
    bit sel_ok, done_clr;
    logic prev_sck;
    logic [15:0] st;
    div = (v.baud < 2) ? 2 : int'(v.baud);
    wr(2'd0, v.baud);
    wr(2'd1, {12'd0, v.sel, v.cpha, v.cpol});
    tb_cpol = v.cpol; tb_cpha = v.cpha;
    m_tx = v.stx; m_rx = '0; m_first = 1'b1; model_on = 1'b1;
    prev_sck = sck_o;
    chk(sck_o == v.cpol, "R4 idle level", sck_o, v.cpol);
    wr(2'd2, {8'd0, v.tx});
    busy_cyc = 0; toggles = 0; sel_ok = 1'b1; done_clr = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      if (mid_wr && busy_cyc == 10) begin
        we = 1'b1; addr = 2'd2; wdata = {8'd0, late};
        @(negedge clk);
        we = 1'b0; addr = 2'd3;
        busy_cyc++;
      end
      #0.5;
      if (!rdata[9]) break;
      if (busy_cyc == 0 && rdata[8]) done_clr = 1'b0;
      for (int i = 0; i < 3; i++)
        if (sel_no[i] != !(v.sel == 2'(i + 1))) sel_ok = 1'b0;
      if (sck_o != prev_sck) toggles++;
      prev_sck = sck_o;
      busy_cyc++;
      @(negedge clk);
    end
    model_on = 1'b0;
    chk(busy_cyc == 17 * div, "R1/R2/R6 busy window", busy_cyc, 17 * div);
    chk(toggles == 16, "R6 edge count", toggles, 16);
    chk(sel_ok, "R5 select decode", sel_no, v.sel);
    chk(done_clr, "R8 done cleared at start", 0, 0);
    chk(m_rx == v.tx, "R3/R7 peripheral received", m_rx, v.tx);
    rd(2'd3, st);
    chk(st[7:0] == v.stx, "R3 received byte", st[7:0], v.stx);
    chk(st[8] == 1'b1, "R8 done set", st[8], 1);
    chk(sck_o == v.cpol && sel_no == 3'b111, "R4 return to idle", {sel_no, sck_o}, {3'b111, v.cpol});
  endtask

  task automatic slave(input logic cpol, input logic cpha, input logic [7:0] txb, input logic [7:0] mb);
    localparam int H = 8;
    logic [7:0] cap;
    logic [15:0] st;
    bit quiet;
    wr(2'd1, {12'd0, 2'd1, cpha, cpol});
    sck_in = cpol;
    repeat (4) @(negedge clk);
    ss_n = 1'b0;
    repeat (6) @(negedge clk);
    wr(2'd2, {8'd0, txb});
    repeat (4) @(negedge clk);
    quiet = 1'b1;
    cap = '0;
    for (int b = 7; b >= 0; b--) begin
      if (!cpha) begin
        mosi_in = mb[b];
        repeat (H) begin @(negedge clk); if (rdata[9] || sel_no != 3'b111) quiet = 1'b0; end
        cap = {cap[6:0], miso_o};
        sck_in = !cpol;
        repeat (H) @(negedge clk);
        sck_in = cpol;
      end else begin
        sck_in = !cpol;
        mosi_in = mb[b];
        repeat (H) begin @(negedge clk); if (rdata[9] || sel_no != 3'b111) quiet = 1'b0; end
        cap = {cap[6:0], miso_o};
        sck_in = cpol;
        repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
    chk(quiet, "R9 no master start, selects high", {sel_no, 1'b0}, 4'hE);
    rd(2'd3, st);
    chk(st[7:0] == mb, "R9 slave received", st[7:0], mb);
    chk(st[8] == 1'b1 && st[9] == 1'b0, "R9/R8 slave done", st[9:8], 1);
    chk(cap == txb, "R9 slave sent", cap, txb);
    ss_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [15:0] r;
    ss_n = 1'b1; sck_in = 1'b0; mosi_in = 1'b0;
    m_tx = '0; m_rx = '0; m_first = 1'b1; model_on = 1'b0; tb_cpol = 1'b0; tb_cpha = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(sel_no == 3'b111, "R10 selects after reset", sel_no, 7);
    chk(sck_o == 1'b0, "R10 clock after reset", sck_o, 0);
    rd(2'd3, r);
    chk(r == 16'd0, "R10 status after reset", r, 0);
    rd(2'd0, r);
    chk(r == 16'd0, "R10 divisor after reset", r, 0);
    for (int k = 0; k < 6; k++) master(VECS[k], 1'b0, 8'h00);
    // R7: write during transfer is not sent and does not restart
    master(VECS[0], 1'b1, 8'h42);
    rd(2'd2, r);
    chk(r[7:0] == 8'h42, "R7 transmit register updated", r[7:0], 8'h42);
    slave(1'b0, 1'b0, 8'h6B, 8'hD2);
    slave(1'b1, 1'b1, 8'h94, 8'h2D);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule